// File: doc/BRIEF.md
# Quad Converter Latch Front End

This block sits in front of a four-channel 8-bit converter and turns a small parallel control interface into actions on four data latches, one per channel (A, B, C, D). A host drives a shared data bus, two active-low select lines, a pair-select line and a read/write line. The block decodes these into writes, readbacks or holds. Each latch's content is presented continuously as that channel's output code, which feeds the analog stage.

Writes can address one channel or two channels together (A with C, or B with D). A readback returns one addressed channel's latch onto the bus. The bidirectional bus is split into an input, an output and an output enable, and the pads are built outside the block. All latch updates happen on the rising edge of a system clock. Reset is synchronous and active-high.

Top module: `qdac_front`

## Requirements
- R1: With `sel1_n` low and `sel2_n` high, a write (`rd_wr` low) loads `bus_in` into channel A when `pair_sel` is 1, or into channel B when it is 0. Channel index 0..3 maps to A..D in `chan_code`. The new code appears after the clock edge that samples the write.
- R2: With `sel1_n` high and `sel2_n` low, a write loads channel C when `pair_sel` is 1, or channel D when it is 0.
- R3: While a write condition stays true, the addressed latch reloads `bus_in` on every rising edge, so the channel's code follows bus changes from cycle to cycle.
- R4: With both selects low and `rd_wr` low, `pair_sel`=1 writes channels A and C together, and `pair_sel`=0 writes channels B and D together. The other two channels are unchanged.
- R5: With both selects high, no channel changes, whatever `pair_sel`, `rd_wr` and `bus_in` are.
- R6: With both selects low and `rd_wr` high, no channel changes and `bus_oe` stays 0.
- R7: With exactly one select low and `rd_wr` high (read), `bus_oe` is 1 in the same cycle. `bus_out` carries the latch of the channel chosen by the R1/R2 decoding.
- R8: On the first edge where the write condition is false, the latch stops loading. It keeps the bus value sampled on the last write edge, and all codes keep showing their latches.
- R9: When `rst` is 1 at a rising edge, all four latches clear to zero. `bus_oe` is 0 while `rst` is 1.
- R10: `bus_oe` is 0 in every write and hold condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel1_n | input | 1 | First select, active low (channels A/B) |
| sel2_n | input | 1 | Second select, active low (channels C/D) |
| pair_sel | input | 1 | 1 picks A or C, 0 picks B or D |
| rd_wr | input | 1 | 1 = read, 0 = write |
| bus_in | input | DATA_W | Data bus from the pads |
| bus_out | output | DATA_W | Readback data to the pads |
| bus_oe | output | 1 | Pad output enable for readback |
| chan_code | output | 4 x DATA_W | Latched code per channel, index 0..3 = A..D |

## Verification
The hardest case to reach is the exit from a write. The latch must hold the bus value of the last write edge and not the value on the bus at the moment the select rises. The stimulus changes `bus_in` on the same negative edge that raises the select, and then changes it again during the hold. Pair writes and the forbidden dual-select read are driven with data that differs from every latch, so a stray load or a stray drive shows up at the ports.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int CH_N = 4;
    localparam int CH_IDX_W = $clog2(CH_N);

    typedef enum logic [1:0] {
        CH_A = 2'd0,
        CH_B = 2'd1,
        CH_C = 2'd2,
        CH_D = 2'd3
    } chan_e;

    typedef struct packed {
        logic [CH_N-1:0] wr_mask;
        logic            rd_en;
        chan_e           rd_ch;
    } ctl_t;

    // Decode of the select/read-write controls into channel actions.
    function automatic ctl_t decode_ctl(
        input logic s1_n,
        input logic s2_n,
        input logic pair,
        input logic rd
    );
        ctl_t c;
        c.wr_mask = '0;
        c.rd_en   = 1'b0;
        c.rd_ch   = CH_A;
        unique case ({s1_n, s2_n})
            2'b01: begin
                c.rd_ch = pair ? CH_A : CH_B;
                if (rd) c.rd_en = 1'b1;
                else    c.wr_mask[c.rd_ch] = 1'b1;
            end
            2'b10: begin
                c.rd_ch = pair ? CH_C : CH_D;
                if (rd) c.rd_en = 1'b1;
                else    c.wr_mask[c.rd_ch] = 1'b1;
            end
            2'b00: begin
                if (!rd) begin
                    if (pair) begin
                        c.wr_mask[CH_A] = 1'b1;
                        c.wr_mask[CH_C] = 1'b1;
                    end else begin
                        c.wr_mask[CH_B] = 1'b1;
                        c.wr_mask[CH_D] = 1'b1;
                    end
                end
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
    import qdac_pkg::*;
(
    input  logic rst,
    input  logic sel1_n,
    input  logic sel2_n,
    input  logic pair_sel,
    input  logic rd_wr,
    output ctl_t ctl
);

    ctl_t raw;

    always_comb begin
        raw = decode_ctl(sel1_n, sel2_n, pair_sel, rd_wr);
        ctl = raw;
        if (rst) begin
            ctl.wr_mask = '0;
            ctl.rd_en   = 1'b0;
        end
    end

endmodule

// File: rtl/qdac_latch_bank.sv
module qdac_latch_bank
    import qdac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [CH_N-1:0]              wr_mask,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [CH_N-1:0][DATA_W-1:0]  latch_q
);

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)             latch_q[g] <= '0;
            else if (wr_mask[g]) latch_q[g] <= wr_data;
        end

        AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
            wr_mask[g] |=> latch_q[g] == $past(wr_data)) else $error("write load"); // R3
        AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !wr_mask[g] |=> $stable(latch_q[g])) else $error("hold"); // R8
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> latch_q == '0) else $error("reset"); // R9

endmodule

// File: rtl/qdac_readmux.sv
module qdac_readmux
    import qdac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [CH_N-1:0][DATA_W-1:0] latch_q,
    input  ctl_t                        ctl,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        rd_oe
);

    always_comb begin
        rd_oe   = ctl.rd_en;
        rd_data = ctl.rd_en ? latch_q[ctl.rd_ch] : '0;
    end

endmodule

// File: rtl/qdac_front.sv
module qdac_front
    import qdac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sel1_n,
    input  logic                        sel2_n,
    input  logic                        pair_sel,
    input  logic                        rd_wr,
    input  logic [DATA_W-1:0]           bus_in,
    output logic [DATA_W-1:0]           bus_out,
    output logic                        bus_oe,
    output logic [CH_N-1:0][DATA_W-1:0] chan_code
);

    ctl_t ctl;

    qdac_decode u_decode (
        .rst      (rst),
        .sel1_n   (sel1_n),
        .sel2_n   (sel2_n),
        .pair_sel (pair_sel),
        .rd_wr    (rd_wr),
        .ctl      (ctl)
    );

    qdac_latch_bank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_mask (ctl.wr_mask),
        .wr_data (bus_in),
        .latch_q (chan_code)
    );

    qdac_readmux #(.DATA_W(DATA_W)) u_rmux (
        .latch_q (chan_code),
        .ctl     (ctl),
        .rd_data (bus_out),
        .rd_oe   (bus_oe)
    );

    AST_BOTH_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sel1_n && sel2_n) |=> $stable(chan_code)) else $error("both high"); // R5
    AST_DUAL_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!sel1_n && !sel2_n && rd_wr) |-> !bus_oe) else $error("dual read"); // R6
    AST_DUAL_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sel1_n && !sel2_n && rd_wr) |=> $stable(chan_code)) else $error("dual read hold"); // R6
    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (sel1_n != sel2_n) && rd_wr) else $error("oe"); // R10
    AST_RESET_NO_OE: assert property (@(posedge clk)
        rst |-> !bus_oe) else $error("oe in reset"); // R9

endmodule

// File: tb/qdac_front_tb_top.sv
module qdac_front_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel1_n, sel2_n, pair_sel, rd_wr;
    logic [DW-1:0] bus_in;
    logic [DW-1:0] bus_out;
    logic          bus_oe;
    logic [3:0][DW-1:0] chan_code;

    logic [DW-1:0] exp_code [4];
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    qdac_front #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .sel1_n(sel1_n), .sel2_n(sel2_n),
        .pair_sel(pair_sel), .rd_wr(rd_wr), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .chan_code(chan_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < 4; i++) chk(req, chan_code[i], exp_code[i]);
    endtask

    // drive controls just after a falling edge
    task automatic drive(input logic s1, input logic s2, input logic p,
                         input logic r, input logic [DW-1:0] d);
        sel1_n = s1; sel2_n = s2; pair_sel = p; rd_wr = r; bus_in = d;
        #1;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle;
        drive(1, 1, 0, 0, 8'hEE);
    endtask

    task automatic t_reset;
        drive(0, 0, 1, 0, 8'h5A);
        rst = 1'b1;
        step();
        step();
        chk("R9", bus_oe, 0);
        for (int i = 0; i < 4; i++) exp_code[i] = '0;
        chk_all("R9");
        drive(0, 1, 1, 1, 8'h00);
        chk("R9", bus_oe, 0);
        rst = 1'b0;
        idle();
        step();
        chk_all("R9");
    endtask

    task automatic t_single_ab;
        drive(0, 1, 1, 0, 8'h11);
        chk("R10", bus_oe, 0);
        step(); exp_code[0] = 8'h11;
        chk_all("R1");
        drive(0, 1, 0, 0, 8'h22);
        step(); exp_code[1] = 8'h22;
        chk_all("R1");
        idle(); step();
    endtask

    task automatic t_single_cd;
        drive(1, 0, 1, 0, 8'h33);
        step(); exp_code[2] = 8'h33;
        chk_all("R2");
        drive(1, 0, 0, 0, 8'h44);
        step(); exp_code[3] = 8'h44;
        chk_all("R2");
        idle(); step();
    endtask

    task automatic t_track_and_exit;
        drive(1, 0, 0, 0, 8'h01);
        step(); exp_code[3] = 8'h01; chk_all("R3");
        drive(1, 0, 0, 0, 8'h02);
        step(); exp_code[3] = 8'h02; chk_all("R3");
        drive(1, 0, 0, 0, 8'h03);
        step(); exp_code[3] = 8'h03; chk_all("R3");
        // select rises together with a bus change
        drive(1, 1, 0, 0, 8'hF0);
        step(); chk_all("R8");
        drive(1, 1, 0, 0, 8'h0F);
        step(); chk_all("R8");
        // leaving via read/write high
        drive(0, 1, 1, 0, 8'h77);
        step(); exp_code[0] = 8'h77;
        drive(0, 1, 1, 1, 8'h99);
        step(); chk_all("R8");
        idle(); step();
    endtask

    task automatic t_pair;
        drive(0, 0, 1, 0, 8'hAC);
        chk("R10", bus_oe, 0);
        step(); exp_code[0] = 8'hAC; exp_code[2] = 8'hAC;
        chk_all("R4");
        drive(0, 0, 0, 0, 8'hBD);
        step(); exp_code[1] = 8'hBD; exp_code[3] = 8'hBD;
        chk_all("R4");
        idle(); step();
    endtask

    task automatic t_hold;
        for (int k = 0; k < 4; k++) begin
            drive(1, 1, k[0], k[1], 8'h5C + 8'(k));
            chk("R10", bus_oe, 0);
            step();
            chk_all("R5");
        end
    endtask

    task automatic t_dual_read;
        drive(0, 0, 1, 1, 8'hC3);
        chk("R6", bus_oe, 0);
        step(); chk_all("R6");
        drive(0, 0, 0, 1, 8'h3C);
        chk("R6", bus_oe, 0);
        step(); chk_all("R6");
        idle(); step();
    endtask

    task automatic t_read;
        drive(0, 1, 1, 1, 8'h00);
        chk("R7", bus_oe, 1); chk("R7", bus_out, exp_code[0]);
        drive(0, 1, 0, 1, 8'h00);
        chk("R7", bus_oe, 1); chk("R7", bus_out, exp_code[1]);
        drive(1, 0, 1, 1, 8'h00);
        chk("R7", bus_oe, 1); chk("R7", bus_out, exp_code[2]);
        drive(1, 0, 0, 1, 8'h00);
        chk("R7", bus_oe, 1); chk("R7", bus_out, exp_code[3]);
        step(); chk_all("R7");
        idle();
        chk("R10", bus_oe, 0);
    endtask

    initial begin
        rst = 1'b1;
        sel1_n = 1'b1; sel2_n = 1'b1; pair_sel = 1'b0; rd_wr = 1'b0; bus_in = '0;
        @(negedge clk);
        t_reset();
        t_single_ab();
        t_single_cd();
        t_track_and_exit();
        t_pair();
        t_hold();
        t_dual_read();
        t_read();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule